// File: doc/BRIEF.md
# Quad Programmable Tap Delay Line

This block holds four independent single-bit delay lines that all run on one sample clock. Each line passes its input to its output without inverting it. The delay is a fixed pipeline latency plus a selectable number of whole clock steps.

Each line has a chain of series storage elements. A per-line address chooses which element is routed to the output. Address zero bypasses the chain entirely, so that setting gives only the base latency.

A separate configuration block supplies the addresses and the per-line enable bits. All of them are captured together on a single load pulse, so every line switches to its new setting on the same clock edge. A cleared enable turns off the line's output drive. The pad ring uses the drive-enable output to put the line's pin into high impedance.

All lines share the same base latency. As a result, lines programmed to the same address stay cycle-aligned.

Reprogramming is glitch-free only when the line's input has been idle for at least the full maximum delay before the load pulse.

Top module: `quad_tap_delay`

## Requirements
- R1: While reset is asserted, and afterwards until the first configuration load, every `line_oe` bit and every `line_out` bit is 0.
- R2: Suppose line i is enabled with latched address a. A value of `line_in[i]` sampled at rising edge k appears on `line_out[i]` right after edge k + BASE_LAT + a − 1, which is BASE_LAT + a clock cycles counting the sampling edge. Rising and falling transitions get the same delay, and the output is never inverted.
- R3: Address 0 gives the minimum delay of exactly BASE_LAT cycles.
- R4: The largest address, 15 with the default 4-bit address, gives the maximum delay of BASE_LAT + 15 cycles.
- R5: Line i takes its enable from `cfg_en[i]` and its address from `cfg_addr[4*i+3 : 4*i]`, using the default 4-bit address. While the latched enable bit is 0, `line_oe[i]` is 0 and `line_out[i]` is held at 0. While it is 1, `line_oe[i]` is 1 and `line_out[i]` carries the delayed data.
- R6: Suppose a line's input has stayed constant for at least BASE_LAT + 15 cycles. Loading any new address for that line then causes no transition on `line_out`.
- R7: Lines that are programmed to the same address and fed identical inputs produce identical outputs in every cycle.
- R8: `cfg_addr` and `cfg_en` are captured only on a rising edge where `cfg_load` is 1, and they are captured for all lines at once. The new enables show on `line_oe` right after that edge. From the edge BASE_LAT cycles later onward, the output follows the new delay. Changes on `cfg_addr` or `cfg_en` while `cfg_load` is 0 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one delay step per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Captures `cfg_addr` and `cfg_en` on the rising edge |
| cfg_addr | input | NUM_LINES*ADDR_W | Packed per-line delay addresses, line 0 in the low bits |
| cfg_en | input | NUM_LINES | Per-line output drive enable |
| line_in | input | NUM_LINES | Line data inputs |
| line_out | output | NUM_LINES | Delayed line data, 0 when the line is disabled |
| line_oe | output | NUM_LINES | Drive enable for the pad; 0 means high impedance |

## Verification
The hardest case to reach is the reprogramming window. The chain must be completely flushed to one level, and then a new address must land while the old and the new taps may both hold stale edges. The stimulus holds every input at a constant level for longer than the maximum delay. It then loads a set of addresses that includes both ends of the range, and keeps the input idle while the scoreboard expects a flat output. This is done once with the idle level low and once with it high. A separate phase changes the configuration inputs every cycle without a load pulse, to show that the latched settings hold.

// File: rtl/qtd_pkg.sv
package qtd_pkg;

   // Tap selector implementation variant
   typedef enum logic {
      TAP_SEL_INDEX,   // direct indexed multiplexer
      TAP_SEL_ANDOR    // decoded one-hot AND-OR tree
   } tap_sel_e;

   // Largest delay in clock cycles for a given address width and base latency
   function automatic int max_delay(input int addr_w, input int base_lat);
      return (2 ** addr_w) - 1 + base_lat;
   endfunction

endpackage

// File: rtl/qtd_cfg_regs.sv
module qtd_cfg_regs #(
   parameter int NUM_LINES = 4,
   parameter int ADDR_W    = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [NUM_LINES*ADDR_W-1:0]   addr_in,
   input  logic [NUM_LINES-1:0]          en_in,
   output logic [NUM_LINES*ADDR_W-1:0]   addr_q,
   output logic [NUM_LINES-1:0]          en_q
);

   // One register bank for all lines: every line switches on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         en_q   <= '0;
      end else if (load) begin
         addr_q <= addr_in;
         en_q   <= en_in;
      end
   end

endmodule

// File: rtl/qtd_tap_line.sv
module qtd_tap_line
   import qtd_pkg::*;
#(
   parameter int       ADDR_W    = 4,
   parameter int       BASE_LAT  = 1,
   parameter tap_sel_e SEL_STYLE = TAP_SEL_INDEX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   input  logic [ADDR_W-1:0] addr,
   output logic              dout
);

   localparam int NUM_ELEM = (2 ** ADDR_W) - 1;
   localparam int NUM_TAPS = NUM_ELEM + 1;

   logic [NUM_ELEM-1:0] chain;
   logic [NUM_TAPS-1:0] taps;
   logic                sel;
   logic [BASE_LAT-1:0] pipe;

   // Series storage elements, one clock step each
   for (genvar k = 0; k < NUM_ELEM; k++) begin : g_elem
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[k] <= 1'b0;
            else        chain[k] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[k] <= 1'b0;
            else        chain[k] <= chain[k-1];
         end
      end
   end

   // Tap 0 is the live input; tap k is the element k steps deep
   assign taps = {chain, din};

   // Tap selector variants
   if (SEL_STYLE == TAP_SEL_INDEX) begin : g_sel_index
      assign sel = taps[addr];
   end else begin : g_sel_andor
      always_comb begin
         sel = 1'b0;
         for (int k = 0; k < NUM_TAPS; k++) begin
            sel = sel | (taps[k] & (addr == ADDR_W'(k)));
         end
      end
   end

   // Base latency pipeline, identical on every line
   for (genvar p = 0; p < BASE_LAT; p++) begin : g_pipe
      if (p == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[p] <= 1'b0;
            else        pipe[p] <= sel;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[p] <= 1'b0;
            else        pipe[p] <= pipe[p-1];
         end
      end
   end

   assign dout = pipe[BASE_LAT-1];

endmodule

// File: rtl/qtd_out_gate.sv
module qtd_out_gate #(
   parameter int NUM_LINES = 4
) (
   input  logic [NUM_LINES-1:0] data,
   input  logic [NUM_LINES-1:0] en,
   output logic [NUM_LINES-1:0] dout,
   output logic [NUM_LINES-1:0] oe
);

   // Disabled lines park low and release the pad drive
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign dout[i] = data[i] & en[i];
      assign oe[i]   = en[i];
   end

endmodule

// File: rtl/quad_tap_delay.sv
module quad_tap_delay
   import qtd_pkg::*;
#(
   parameter int       NUM_LINES = 4,
   parameter int       ADDR_W    = 4,
   parameter int       BASE_LAT  = 1,
   parameter tap_sel_e SEL_STYLE = TAP_SEL_INDEX
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_load,
   input  logic [NUM_LINES*ADDR_W-1:0] cfg_addr,
   input  logic [NUM_LINES-1:0]        cfg_en,
   input  logic [NUM_LINES-1:0]        line_in,
   output logic [NUM_LINES-1:0]        line_out,
   output logic [NUM_LINES-1:0]        line_oe
);

   localparam int MAX_DLY = max_delay(ADDR_W, BASE_LAT);

   // Elaboration-time parameter checks
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("quad_tap_delay: NUM_LINES must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("quad_tap_delay: ADDR_W must lie in 1..8");
   end
   if (BASE_LAT < 1 || MAX_DLY > 4096) begin : g_bad_lat
      $error("quad_tap_delay: BASE_LAT must be at least 1 and total delay bounded");
   end

   logic [NUM_LINES*ADDR_W-1:0] cur_addr;
   logic [NUM_LINES-1:0]        cur_en;
   logic [NUM_LINES-1:0]        tap_data;

   qtd_cfg_regs #(
      .NUM_LINES (NUM_LINES),
      .ADDR_W    (ADDR_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cfg_load),
      .addr_in (cfg_addr),
      .en_in   (cfg_en),
      .addr_q  (cur_addr),
      .en_q    (cur_en)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      qtd_tap_line #(
         .ADDR_W    (ADDR_W),
         .BASE_LAT  (BASE_LAT),
         .SEL_STYLE (SEL_STYLE)
      ) u_tap (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (line_in[i]),
         .addr  (cur_addr[i*ADDR_W +: ADDR_W]),
         .dout  (tap_data[i])
      );
   end

   qtd_out_gate #(
      .NUM_LINES (NUM_LINES)
   ) u_gate (
      .data (tap_data),
      .en   (cur_en),
      .dout (line_out),
      .oe   (line_oe)
   );

endmodule

// File: rtl/qtd_checker.sv
module qtd_checker #(
   parameter int NUM_LINES = 4,
   parameter int ADDR_W    = 4,
   parameter int BASE_LAT  = 1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cfg_load,
   input logic [NUM_LINES-1:0]        line_in,
   input logic [NUM_LINES-1:0]        line_out,
   input logic [NUM_LINES-1:0]        line_oe,
   input logic [NUM_LINES*ADDR_W-1:0] cur_addr
);

   localparam int MAXD      = (2 ** ADDR_W) - 1 + BASE_LAT;
   localparam int IDLE_FULL = MAXD + 1;
   localparam int CW        = $clog2(IDLE_FULL + 2);

   // Edges since the last configuration load, saturating at BASE_LAT
   logic [CW-1:0] since_load;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          since_load <= '0;
      else if (cfg_load)                   since_load <= '0;
      else if (int'(since_load) < BASE_LAT) since_load <= since_load + 1'b1;
   end

   AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_load) |-> $stable(line_oe)); // R8

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
      logic [MAXD-1:0]   hist;
      logic [CW-1:0]     idle_cnt;
      logic [ADDR_W-1:0] a;
      int                idx;

      assign a   = cur_addr[i*ADDR_W +: ADDR_W];
      assign idx = int'(a) + BASE_LAT - 1;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist     <= '0;
            idle_cnt <= '0;
         end else begin
            hist <= {hist[MAXD-2:0], line_in[i]};
            if (line_in[i] != hist[0])            idle_cnt <= CW'(1);
            else if (int'(idle_cnt) < IDLE_FULL)  idle_cnt <= idle_cnt + 1'b1;
         end
      end

      AST_TAP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
         (line_oe[i] && int'(since_load) >= BASE_LAT) |-> (line_out[i] == hist[idx])); // R2

      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(idle_cnt) >= IDLE_FULL && $stable(line_oe[i])) |-> $stable(line_out[i])); // R6

      AST_OFF_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(cfg_load) && !line_oe[i]) |-> (line_out[i] == 1'b0)); // R5
   end

endmodule

bind quad_tap_delay qtd_checker #(
   .NUM_LINES (NUM_LINES),
   .ADDR_W    (ADDR_W),
   .BASE_LAT  (BASE_LAT)
) u_qtd_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_load (cfg_load),
   .line_in  (line_in),
   .line_out (line_out),
   .line_oe  (line_oe),
   .cur_addr (cur_addr)
);

// File: tb/tb_quad_tap_delay.sv
module tb_quad_tap_delay;

   localparam int NL = 4;
   localparam int AW = 4;
   localparam int BL = 1;
   localparam int WATCHDOG = 5000;

   typedef struct {
      int due;
      bit val;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_load = 1'b0;
   logic [NL*AW-1:0]  cfg_addr = '0;
   logic [NL-1:0]     cfg_en = '0;
   logic [NL-1:0]     line_in = '0;
   logic [NL-1:0]     line_out;
   logic [NL-1:0]     line_oe;

   quad_tap_delay #(.NUM_LINES(NL), .ADDR_W(AW), .BASE_LAT(BL)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_load (cfg_load),
      .cfg_addr (cfg_addr),
      .cfg_en   (cfg_en),
      .line_in  (line_in),
      .line_out (line_out),
      .line_oe  (line_oe)
   );

   always #2.5 clk = ~clk;   // 200 MHz

   int        cyc = 0;
   int        checks = 0;
   int        fails = 0;
   bit        done = 0;
   item_t     sb [NL][$];
   bit        lvl [NL];
   int        cur_a [NL];
   logic [NL-1:0] exp_oe = '0;
   logic [NL-1:0] oe_next = '0;
   int        oe_due = -1;
   string     phase = "R1";
   bit        match_mode = 0;
   bit        scramble = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   function automatic string tag_for(input int i);
      if (phase == "R2") begin
         if (cur_a[i] == 0)  return "R3";
         if (cur_a[i] == 15) return "R4";
      end
      return phase;
   endfunction

   // Driver: applies one input vector and pushes the expected output item per line
   task automatic drive_cycle(input logic [NL-1:0] v);
      @(negedge clk);
      cfg_load = 1'b0;
      if (scramble) begin
         cfg_addr = NL*AW'($urandom);
         cfg_en   = NL'($urandom);
      end
      line_in = v;
      for (int i = 0; i < NL; i++) sb[i].push_back('{cyc + BL + cur_a[i], v[i]});
   endtask

   task automatic idle(input int n, input bit level);
      for (int k = 0; k < n; k++) drive_cycle({NL{level}});
   endtask

   task automatic load_cfg(input int a3, input int a2, input int a1, input int a0,
                           input logic [NL-1:0] en, input bit level);
      @(negedge clk);
      cfg_addr = {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
      cfg_en   = en;
      cfg_load = 1'b1;
      line_in  = {NL{level}};
      cur_a[3] = a3; cur_a[2] = a2; cur_a[1] = a1; cur_a[0] = a0;
      oe_next  = en;
      oe_due   = cyc + 1;
      for (int i = 0; i < NL; i++) begin
         sb[i].delete();
         lvl[i] = level;
         sb[i].push_back('{cyc + BL + cur_a[i], level});
      end
   endtask

   task automatic random_run(input int n, input bit broadcast);
      for (int k = 0; k < n; k++) begin
         if (broadcast) drive_cycle({NL{1'($urandom)}});
         else           drive_cycle(NL'($urandom));
      end
   endtask

   // Monitor: pops expected items as they fall due and compares the outputs
   always @(negedge clk) begin
      if (!done) begin
         if (cyc == oe_due) exp_oe = oe_next;
         for (int i = 0; i < NL; i++) begin
            if (sb[i].size() > 0 && sb[i][0].due == cyc) begin
               lvl[i] = sb[i][0].val;
               void'(sb[i].pop_front());
            end
            chk(line_out[i] == (lvl[i] & exp_oe[i]), tag_for(i),
                int'(line_out[i]), int'(lvl[i] & exp_oe[i]));
         end
         chk(line_oe == exp_oe, (phase == "R1") ? "R1" : "R5",
             int'(line_oe), int'(exp_oe));
         if (match_mode && exp_oe == '1)
            chk(line_out == '0 || line_out == '1, "R7", int'(line_out), 0);
      end
   end

   // Watchdog
   always @(posedge clk) begin
      if (!done && cyc > WATCHDOG) begin
         fails++;
         $display("FAIL watchdog: run hung at cycle %0d, actual %0d expected %0d", cyc, cyc, WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NL; i++) begin
         lvl[i] = 1'b0;
         cur_a[i] = 0;
      end
      // R1: reset state and no output before the first load
      phase = "R1";
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      random_run(8, 0);

      // R2, R3 (address 0), R4 (address 15): mixed addresses, random inputs
      idle(20, 0);
      phase = "R2";
      load_cfg(7, 15, 5, 0, 4'b1111, 0);
      random_run(80, 0);

      // R8: configuration inputs change without a load pulse
      phase = "R8";
      scramble = 1;
      random_run(40, 0);
      scramble = 0;

      // R7: matched addresses with identical inputs
      idle(20, 1);
      phase = "R7";
      load_cfg(9, 9, 9, 9, 4'b1111, 1);
      match_mode = 1;
      random_run(40, 1);
      match_mode = 0;

      // R5: partial enables
      idle(20, 1);
      phase = "R5";
      load_cfg(6, 0, 11, 2, 4'b0101, 1);
      random_run(40, 0);

      // R6: reprogram while idle low, then while idle high
      idle(20, 0);
      phase = "R6";
      load_cfg(3, 8, 0, 15, 4'b1111, 0);
      idle(25, 0);
      phase = "R2";
      idle(20, 1);
      phase = "R6";
      load_cfg(14, 1, 15, 0, 4'b1111, 1);
      idle(25, 1);

      // R2 again after the reprogram
      phase = "R2";
      random_run(40, 0);
      idle(20, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule